// File: doc/BRIEF.md
# Interlocked glitch-free base clock selector

The block produces a base clock and a bus clock from one of two free-running sources: a fixed oscillator clock and a divided PLL-derived clock. A small control front end, clocked by the oscillator, takes processor writes carrying a PLL-enable bit, a source-select bit and a loop multiplier factor. It refuses any write that would leave the derived clock selected while the PLL is off or unconfigured. The control logic then turns the effective choice into a switch request.

The switch passes the request into each clock domain through a synchronizer. It drops the enable of the old source on that source's falling edge. The new source is enabled only once the old enable is seen low. While this happens the gated output stays frozen, so no pulse is shortened. The muxed clock goes through a divide-by-two stage to give the base clock with an even duty cycle. A second divide-by-two gives the bus clock at a quarter of the selected source rate. A status output tells which source is currently passing.

Top module: `base_clk_sel`

## Requirements
- R1: After reset the PLL-enable bit reads 0, the select bit reads 0, the multiplier reads 0, the status output reads 0 (oscillator active), and the base and bus clocks are derived from the oscillator clock.
- R2: Every write stores its multiplier value, even when other fields of the same write are refused.
- R3: A write that sets the select bit to 1 (derived clock) while the stored PLL-enable bit is 0 leaves the select bit unchanged.
- R4: A write that clears the PLL-enable bit to 0 while the stored select bit is 1 leaves the PLL-enable bit unchanged.
- R5: A write whose PLL-enable and select values both differ from the stored ones changes neither of those two bits.
- R6: While the stored multiplier is zero the oscillator clock drives the outputs even with select and PLL-enable both 1; a later nonzero multiplier brings the derived clock back.
- R7: The base clock period is twice the selected source period with a high time of one source period, and the bus clock period is four times the selected source period.
- R8: Across every source change, no high or low pulse on the base or bus clock is shorter than half the period of the faster source, and the two source enables are never on together.
- R9: The status output is 1 exactly when the derived clock is passing, and it follows a legal select change within 20 oscillator cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock, also clocks the control front end |
| pll_clk | input | 1 | Divided PLL-derived clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on osc_clk rising edge |
| wr_pll_on | input | 1 | Written PLL-enable value |
| wr_sel_pll | input | 1 | Written select value, 1 = derived clock |
| wr_mult | input | MULT_W | Written loop multiplier factor |
| rd_pll_on | output | 1 | Stored PLL-enable bit |
| rd_sel_pll | output | 1 | Stored select bit |
| rd_mult | output | MULT_W | Stored multiplier |
| src_pll_active | output | 1 | 1 while the derived clock is passing |
| base_clk | output | 1 | Muxed clock divided by two |
| bus_clk | output | 1 | Base clock divided by two |

## Verification
The bench builds the block with a 4-bit multiplier and two synchronizer stages. The narrow multiplier makes the zero value that forces the oscillator easy to reach, and it lets the bench move between zero and nonzero factors while the derived clock is selected. The two sources run at 8 ns and 5.2 ns, which keeps their phase drifting. As a result, successive switches land at different relative phases of the two clocks, and the pulse-width monitor sees the hand-over at many alignments.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;
  typedef struct packed {
    logic pll_on;
    logic sel_pll;
  } ctl_t;

  localparam int unsigned DIV_CHAIN = 2;
endpackage

// File: rtl/clk_rst_sync.sv
module clk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/clk_ctrl_regs.sv
module clk_ctrl_regs
  import clk_sel_pkg::*;
#(
  parameter int unsigned MULT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_pll_on,
  input  logic              wr_sel_pll,
  input  logic [MULT_W-1:0] wr_mult,
  output logic              pll_on,
  output logic              sel_pll,
  output logic [MULT_W-1:0] mult,
  output logic              pll_req
);
  ctl_t              ctl_q, ctl_d;
  logic [MULT_W-1:0] mult_q, mult_d;
  logic              req_q, req_d;
  logic              on_chg, sel_chg;

  always_comb begin
    on_chg  = wr_pll_on  != ctl_q.pll_on;
    sel_chg = wr_sel_pll != ctl_q.sel_pll;
    ctl_d   = ctl_q;
    mult_d  = mult_q;
    if (wr_en) begin
      mult_d = wr_mult;
      if (!(on_chg && sel_chg)) begin
        if (on_chg && !(!wr_pll_on && ctl_q.sel_pll)) ctl_d.pll_on = wr_pll_on;
        if (sel_chg && !(wr_sel_pll && !ctl_q.pll_on)) ctl_d.sel_pll = wr_sel_pll;
      end
    end
    req_d = ctl_d.sel_pll && ctl_d.pll_on && (mult_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      mult_q <= '0;
      req_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        ctl_q  <= ctl_d;
        mult_q <= mult_d;
      end
      req_q <= req_d;
    end
  end

  assign pll_on  = ctl_q.pll_on;
  assign sel_pll = ctl_q.sel_pll;
  assign mult    = mult_q;
  assign pll_req = req_q;

  AST_SEL_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.sel_pll |-> ctl_q.pll_on); // R3

  AST_KEEP_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ctl_q.sel_pll && ctl_q.pll_on && !wr_pll_on) |=> ctl_q.pll_on); // R4

  AST_NO_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_pll_on != ctl_q.pll_on) && (wr_sel_pll != ctl_q.sel_pll))
    |=> ($stable(ctl_q.pll_on) && $stable(ctl_q.sel_pll))); // R5

  AST_MULT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mult_q == $past(wr_mult))); // R2
endmodule

// File: rtl/clk_gate_leg.sv
module clk_gate_leg #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic want,
  input  logic other_en,
  output logic en
);
  logic                   srst_n;
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   en_q, en_d;

  clk_rst_sync #(.STAGES(SYNC_STAGES)) i_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], want && !other_en};
    en_d   = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  always_ff @(negedge clk or negedge srst_n) begin
    if (!srst_n) en_q <= 1'b0;
    else         en_q <= en_d;
  end

  assign en = en_q;
endmodule

// File: rtl/clk_div2.sv
module clk_div2 (
  input  logic clk,
  input  logic rst_n,
  output logic q
);
  logic q_q, q_d;

  always_comb q_d = !q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q = q_q;

  AST_DIV_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q_q != $past(q_q))); // R7
endmodule

// File: rtl/base_clk_sel.sv
module base_clk_sel
  import clk_sel_pkg::*;
#(
  parameter int unsigned MULT_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              osc_clk,
  input  logic              pll_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_pll_on,
  input  logic              wr_sel_pll,
  input  logic [MULT_W-1:0] wr_mult,
  output logic              rd_pll_on,
  output logic              rd_sel_pll,
  output logic [MULT_W-1:0] rd_mult,
  output logic              src_pll_active,
  output logic              base_clk,
  output logic              bus_clk
);
  logic           ctl_rst_n;
  logic           pll_req;
  logic           en_osc, en_pll;
  logic [DIV_CHAIN:0] tap;

  clk_rst_sync #(.STAGES(SYNC_STAGES)) i_ctl_rst (
    .clk    (osc_clk),
    .arst_n (rst_n),
    .srst_n (ctl_rst_n)
  );

  clk_ctrl_regs #(.MULT_W(MULT_W)) i_regs (
    .clk        (osc_clk),
    .rst_n      (ctl_rst_n),
    .wr_en      (wr_en),
    .wr_pll_on  (wr_pll_on),
    .wr_sel_pll (wr_sel_pll),
    .wr_mult    (wr_mult),
    .pll_on     (rd_pll_on),
    .sel_pll    (rd_sel_pll),
    .mult       (rd_mult),
    .pll_req    (pll_req)
  );

  clk_gate_leg #(.SYNC_STAGES(SYNC_STAGES)) i_leg_osc (
    .clk      (osc_clk),
    .arst_n   (rst_n),
    .want     (!pll_req),
    .other_en (en_pll),
    .en       (en_osc)
  );

  clk_gate_leg #(.SYNC_STAGES(SYNC_STAGES)) i_leg_pll (
    .clk      (pll_clk),
    .arst_n   (rst_n),
    .want     (pll_req),
    .other_en (en_osc),
    .en       (en_pll)
  );

  assign tap[0] = (osc_clk && en_osc) || (pll_clk && en_pll);

  for (genvar g = 0; g < DIV_CHAIN; g++) begin : g_div
    clk_div2 i_div (
      .clk   (tap[g]),
      .rst_n (rst_n),
      .q     (tap[g+1])
    );
  end

  assign base_clk       = tap[1];
  assign bus_clk        = tap[DIV_CHAIN];
  assign src_pll_active = en_pll;

  AST_ONE_SOURCE: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !(en_osc && en_pll)); // R8
endmodule

// File: tb/test_base_clk_sel.sv
`timescale 1ns/1ps
module test_base_clk_sel;
  localparam int MW = 4;
  localparam real T_OSC = 8.0;
  localparam real T_PLL = 5.2;

  logic osc_clk = 1'b0, pll_clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_pll_on = 1'b0, wr_sel_pll = 1'b0;
  logic [MW-1:0] wr_mult = '0;
  logic rd_pll_on, rd_sel_pll, src_pll_active, base_clk, bus_clk;
  logic [MW-1:0] rd_mult;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(T_OSC/2) osc_clk = !osc_clk;
  always #(T_PLL/2) pll_clk = !pll_clk;

  base_clk_sel #(.MULT_W(MW), .SYNC_STAGES(2)) i_base_clk_sel (
    .osc_clk(osc_clk), .pll_clk(pll_clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_pll_on(wr_pll_on), .wr_sel_pll(wr_sel_pll), .wr_mult(wr_mult),
    .rd_pll_on(rd_pll_on), .rd_sel_pll(rd_sel_pll), .rd_mult(rd_mult),
    .src_pll_active(src_pll_active), .base_clk(base_clk), .bus_clk(bus_clk));

  typedef struct { bit on; bit sel; logic [MW-1:0] mult; string tag; } item_t;
  item_t sb_q[$];
  event wr_done;
  bit m_on = 0, m_sel = 0;

  task automatic chk(bit ok, string tag, string what, real act, real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0.3f expected=%0.3f", tag, what, act, exp);
    end
  endtask

  // driver: applies a write and pushes the expected read-back
  task automatic do_write(bit on, bit sel, logic [MW-1:0] m, string tag);
    item_t it;
    bit dual;
    @(negedge osc_clk);
    wr_en = 1; wr_pll_on = on; wr_sel_pll = sel; wr_mult = m;
    @(negedge osc_clk);
    wr_en = 0;
    dual = (on != m_on) && (sel != m_sel);
    if (!dual) begin
      if (sel && !m_sel) begin if (m_on) m_sel = 1; end
      else if (!sel && m_sel) m_sel = 0;
      if (!on && m_on) begin if (!m_sel) m_on = 0; end
      else if (on && !m_on) m_on = 1;
    end
    it.on = m_on; it.sel = m_sel; it.mult = m; it.tag = tag;
    sb_q.push_back(it);
    ->wr_done;
  endtask

  // monitor: compares read-back with queued expectations
  initial forever begin
    item_t it;
    @(wr_done);
    #1;
    while (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      chk(rd_pll_on == it.on, it.tag, "pll_on", rd_pll_on, it.on);
      chk(rd_sel_pll == it.sel, it.tag, "sel", rd_sel_pll, it.sel);
      chk(rd_mult == it.mult, "R2", "mult", rd_mult, it.mult);
    end
  end

  // pulse-width monitor (R8)
  real min_w = 1.0e9, lb = 0.0, lu = 0.0;
  bit mon_on = 0, sb = 0, su = 0;
  always @(base_clk) if (mon_on) begin
    if (sb && ($realtime - lb) < min_w) min_w = $realtime - lb;
    lb = $realtime; sb = 1;
  end
  always @(bus_clk) if (mon_on) begin
    if (su && ($realtime - lu) < min_w) min_w = $realtime - lu;
    lu = $realtime; su = 1;
  end

  task automatic check_src(bit exp_pll, string tag);
    real t0, t1, t2, ts;
    repeat (20) @(posedge osc_clk);
    #1;
    chk(src_pll_active == exp_pll, tag, "status", src_pll_active, exp_pll);
    ts = exp_pll ? T_PLL : T_OSC;
    @(posedge base_clk); t0 = $realtime;
    @(negedge base_clk); t1 = $realtime;
    @(posedge base_clk); t2 = $realtime;
    chk((t2-t0) > 2*ts-0.01 && (t2-t0) < 2*ts+0.01, "R7", "base period", t2-t0, 2*ts);
    chk((t1-t0) > ts-0.01 && (t1-t0) < ts+0.01, "R7", "base high", t1-t0, ts);
    @(posedge bus_clk); t0 = $realtime;
    @(posedge bus_clk); t1 = $realtime;
    chk((t1-t0) > 4*ts-0.01 && (t1-t0) < 4*ts+0.01, "R7", "bus period", t1-t0, 4*ts);
  endtask

  initial begin
    #(200000.0);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge osc_clk);
    rst_n = 1;
    repeat (10) @(negedge osc_clk);
    mon_on = 1;
    chk(rd_pll_on == 0, "R1", "pll_on", rd_pll_on, 0);
    chk(rd_sel_pll == 0, "R1", "sel", rd_sel_pll, 0);
    chk(rd_mult == 0, "R1", "mult", rd_mult, 0);
    check_src(0, "R1");
    do_write(1, 1, 4'd5, "R5");   // both change: refused
    do_write(0, 1, 4'd5, "R3");   // select while off: refused
    check_src(0, "R3");
    do_write(1, 0, 4'd5, "R4");   // enable PLL
    do_write(1, 1, 4'd5, "R9");   // select derived clock
    check_src(1, "R9");
    do_write(0, 1, 4'd5, "R4");   // clear enable while selected: refused
    check_src(1, "R4");
    do_write(1, 1, 4'd0, "R6");   // zero multiplier forces oscillator
    check_src(0, "R6");
    do_write(1, 1, 4'd7, "R6");   // nonzero brings derived clock back
    check_src(1, "R6");
    do_write(0, 0, 4'd3, "R5");   // both change: refused
    check_src(1, "R5");
    do_write(1, 0, 4'd3, "R9");   // back to oscillator
    check_src(0, "R9");
    do_write(0, 0, 4'd1, "R4");   // now enable may clear
    do_write(1, 0, 4'd2, "R9");
    do_write(1, 1, 4'd2, "R9");
    check_src(1, "R8");
    do_write(1, 0, 4'd2, "R9");
    check_src(0, "R8");
    chk(min_w >= T_PLL/2, "R8", "min pulse", min_w, T_PLL/2);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule